// File: doc/BRIEF.md
# Single-Register Load/Store Execution Unit

This unit carries out one single-register load or store for a 32-bit RISC core. It accepts an instruction word together with six mode bits. The bits choose between an immediate and a shifted-register offset (I), pre- and post-indexing (P), add or subtract (U), byte or word size (B), base writeback (W) and load or store (L). In the cycle an instruction is accepted, the unit reads the base, offset and source registers from a combinational register-file read port and samples the current pipeline PC. It then forms the offset and the effective address and registers one bus request.

The request stays on a valid/ready memory bus until it is accepted. Byte accesses use the exact address and one lane strobe. Word accesses are forced to an aligned address and drive all four strobes. When a word load is misaligned, the unit rotates the returned aligned word instead of raising a fault. One cycle after the handshake, the unit presents up to two register writes for one cycle, marked by `done`: the loaded value and the adjusted base.

Top module: `ldst_unit`

## Requirements
- R1: The unit drives the register read indices combinationally from the instruction: the base index from bits [19:16], the data index from bits [15:12] and the offset index from bits [3:0].
- R2: When the base index is 15, the base is `pcValue` for a load and `pcValue` + 4 for a store. The register file's copy of register 15 is ignored for the base.
- R3: With I=0, the offset is bits [11:0] of the instruction, zero-extended.
- R4: With I=1, the offset is the offset register shifted by the amount in bits [11:7], using the type in bits [6:5]: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right.
- R5: A zero shift amount has these meanings: logical left passes the value through; logical right gives 0; arithmetic right fills every bit with bit 31; rotate right shifts the value right by one and puts `carryIn` into bit 31.
- R6: The adjusted base is the base plus the offset when U=1 and the base minus the offset when U=0. The access address is the adjusted base when P=1 and the unmodified base when P=0.
- R7: A byte load takes byte lane addr[1:0] of `memRdata` (lane k is bits [8k+7:8k]) and zero-extends it. The bus address for a byte access is exact.
- R8: A word load places address {addr[31:2],00} on the bus and returns `memRdata` rotated right by 8·addr[1:0].
- R9: A store sets `memWrite`=1. A word store drives an aligned address, strobe 4'b1111 and the full data register. A byte store drives strobe bit addr[1:0] alone, with data bits [7:0] on every lane. A load sets `memWrite`=0.
- R10: `wbBaseEn` is 1 in the `done` cycle when P=0 or W=1, and it carries the adjusted base and the base index. Otherwise it is 0.
- R11: For a load, `wbDataEn` is 1 in the `done` cycle. The exception is a load where the base is written back and the data index equals the base index: then only the base write is presented. A store never asserts `wbDataEn`.
- R12: `memValid` and `busy` rise in the cycle after `start` is accepted while idle. The request holds a stable address until the cycle in which `memReady` is 1. `done` is a single-cycle pulse in the following cycle, and `busy` is 0 from then on.
- R13: After reset, `memValid`, `busy`, `done`, `wbDataEn` and `wbBaseEn` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | Instruction accept request, taken while idle |
| instr | input | 32 | Instruction word |
| modeI | input | 1 | 1 = shifted-register offset |
| modeP | input | 1 | 1 = pre-indexed address |
| modeU | input | 1 | 1 = add offset |
| modeB | input | 1 | 1 = byte access |
| modeW | input | 1 | 1 = write back base (pre-indexed) |
| modeL | input | 1 | 1 = load, 0 = store |
| carryIn | input | 1 | Carry flag for extended rotate |
| pcValue | input | 32 | Pipeline PC (instruction address + 8) |
| rdIdxBase | output | 4 | Base register read index |
| rdIdxOff | output | 4 | Offset register read index |
| rdIdxSrc | output | 4 | Data register read index |
| rdValBase | input | 32 | Base register value |
| rdValOff | input | 32 | Offset register value |
| rdValSrc | input | 32 | Data register value |
| memValid | output | 1 | Bus request valid |
| memReady | input | 1 | Bus request accepted |
| memAddr | output | 32 | Bus address |
| memWrite | output | 1 | 1 = write |
| memStrobe | output | 4 | Byte lane strobes |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, aligned word, valid with memReady |
| busy | output | 1 | Access in progress |
| done | output | 1 | Register writes presented this cycle |
| wbDataEn | output | 1 | Loaded-data write enable |
| wbDataReg | output | 4 | Loaded-data destination index |
| wbDataVal | output | 32 | Loaded data |
| wbBaseEn | output | 1 | Base writeback enable |
| wbBaseReg | output | 4 | Base writeback index |
| wbBaseVal | output | 32 | Adjusted base |

## Verification
The shifted-register path is swept over all four shift types, at amounts 0, 1, 7 and 31, with both carry values, and on operands with bit 31 set and clear. This separates the zero-amount special meanings from ordinary shifts and logical from arithmetic fill. The immediate path is swept over every combination of P, U, W, B and L at all four low-address alignments. These sweeps tell apart the pre- and post-indexed address, rotated word loads and the byte lane choice, the strobe and data patterns of stores, and the writeback rule. Further cases cover a PC base with a load and with a store, which checks the extra 4, and loads whose data index equals the base index with and without writeback. Bus latencies from zero to three wait cycles check that the request is held.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int XLEN    = 32;
  localparam int REG_W   = 4;
  localparam int LANES   = XLEN / 8;
  localparam int LANE_W  = $clog2(LANES);
  localparam int SHW     = $clog2(XLEN);
  localparam int IMM_W   = 12;
  localparam logic [REG_W-1:0] PC_IDX = '1;

  typedef enum logic [1:0] {SH_LSL, SH_LSR, SH_ASR, SH_ROR} shiftKind_e;

  typedef struct packed {
    logic i;
    logic p;
    logic u;
    logic b;
    logic w;
    logic l;
  } ldMode_t;

  typedef struct packed {
    logic acceptReq;
    logic captureRsp;
  } ctrlStrobe_t;
endpackage

// File: rtl/ldst_shifter.sv
module ldst_shifter
  import ldst_pkg::*;
(
  input  logic [XLEN-1:0] value,
  input  logic [SHW-1:0]  amount,
  input  shiftKind_e      kind,
  input  logic            carryIn,
  output logic [XLEN-1:0] result
);
  localparam logic [SHW:0] FULL = (SHW+1)'(XLEN);
  logic [SHW:0] backAmt;
  logic         isZero;

  assign backAmt = FULL - {1'b0, amount};
  assign isZero  = (amount == '0);

  always_comb begin
    unique case (kind)
      SH_LSL: result = value << amount;
      SH_LSR: result = isZero ? '0 : (value >> amount);
      SH_ASR: result = isZero ? {XLEN{value[XLEN-1]}} : XLEN'($signed(value) >>> amount);
      default: result = isZero ? {carryIn, value[XLEN-1:1]}
                               : ((value >> amount) | (value << backAmt));
    endcase
  end
endmodule

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        memReady,
  output ctrlStrobe_t strobe,
  output logic        memValid,
  output logic        busy,
  output logic        done
);
  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_FINISH} ctrlState_e;
  ctrlState_e state, stateNext;

  always_comb begin
    strobe.acceptReq  = (state == ST_IDLE) && start;
    strobe.captureRsp = (state == ST_ACCESS) && memReady;
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (start) stateNext = ST_ACCESS;
      ST_ACCESS: if (memReady) stateNext = ST_FINISH;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign memValid = (state == ST_ACCESS);
  assign busy     = (state == ST_ACCESS);
  assign done     = (state == ST_FINISH);
endmodule

// File: rtl/ldst_datapath.sv
module ldst_datapath
  import ldst_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [XLEN-1:0]   instr,
  input  ldMode_t           mode,
  input  logic              carryIn,
  input  logic [XLEN-1:0]   pcValue,
  input  logic [XLEN-1:0]   baseRaw,
  input  logic [XLEN-1:0]   offRaw,
  input  logic [XLEN-1:0]   srcRaw,
  input  logic [XLEN-1:0]   memRdata,
  output logic [REG_W-1:0]  rnIdx,
  output logic [REG_W-1:0]  rmIdx,
  output logic [REG_W-1:0]  rdIdx,
  output logic [XLEN-1:0]   memAddr,
  output logic              memWrite,
  output logic [LANES-1:0]  memStrobe,
  output logic [XLEN-1:0]   memWdata,
  output logic              dataWant,
  output logic              baseWant,
  output logic [REG_W-1:0]  dataReg,
  output logic [REG_W-1:0]  baseReg,
  output logic [XLEN-1:0]   dataVal,
  output logic [XLEN-1:0]   baseVal
);
  localparam logic [SHW:0] FULL = (SHW+1)'(XLEN);

  logic [XLEN-1:0]   baseSel, regOff, offset, adjusted, effAddr;
  logic              wantBase;
  logic [LANE_W-1:0] lowQ;
  logic              byteQ;
  logic [SHW:0]      rotAmt;
  logic [XLEN-1:0]   shiftedRd, rotatedRd;

  assign rnIdx = instr[19:16];
  assign rdIdx = instr[15:12];
  assign rmIdx = instr[REG_W-1:0];

  // PC base: stores see a further 4 bytes ahead
  assign baseSel = (rnIdx == PC_IDX) ? (pcValue + (mode.l ? XLEN'(0) : XLEN'(4))) : baseRaw;

  ldst_shifter u_shift (
    .value   (offRaw),
    .amount  (instr[11:7]),
    .kind    (shiftKind_e'(instr[6:5])),
    .carryIn (carryIn),
    .result  (regOff)
  );

  assign offset   = mode.i ? regOff : XLEN'(instr[IMM_W-1:0]);
  assign adjusted = mode.u ? (baseSel + offset) : (baseSel - offset);
  assign effAddr  = mode.p ? adjusted : baseSel;
  assign wantBase = !mode.p || mode.w;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr   <= '0;
      memWrite  <= 1'b0;
      memStrobe <= '0;
      memWdata  <= '0;
      dataWant  <= 1'b0;
      baseWant  <= 1'b0;
      dataReg   <= '0;
      baseReg   <= '0;
      baseVal   <= '0;
      lowQ      <= '0;
      byteQ     <= 1'b0;
    end else if (strobe.acceptReq) begin
      memAddr   <= mode.b ? effAddr : {effAddr[XLEN-1:LANE_W], {LANE_W{1'b0}}};
      memWrite  <= !mode.l;
      memStrobe <= mode.b ? (LANES'(1) << effAddr[LANE_W-1:0]) : '1;
      memWdata  <= mode.b ? {LANES{srcRaw[7:0]}} : srcRaw;
      baseWant  <= wantBase;
      dataWant  <= mode.l && !(wantBase && (rdIdx == rnIdx));
      dataReg   <= rdIdx;
      baseReg   <= rnIdx;
      baseVal   <= adjusted;
      lowQ      <= effAddr[LANE_W-1:0];
      byteQ     <= mode.b;
    end
  end

  // load alignment: lane pick for bytes, rotation for words
  assign rotAmt    = (SHW+1)'({lowQ, 3'b000});
  assign shiftedRd = memRdata >> rotAmt;
  assign rotatedRd = shiftedRd | (memRdata << (FULL - rotAmt));

  always_ff @(posedge clk) begin
    if (!rstN)                  dataVal <= '0;
    else if (strobe.captureRsp) dataVal <= byteQ ? XLEN'(shiftedRd[7:0]) : rotatedRd;
  end
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] instr,
  input  logic        modeI,
  input  logic        modeP,
  input  logic        modeU,
  input  logic        modeB,
  input  logic        modeW,
  input  logic        modeL,
  input  logic        carryIn,
  input  logic [31:0] pcValue,
  output logic [3:0]  rdIdxBase,
  output logic [3:0]  rdIdxOff,
  output logic [3:0]  rdIdxSrc,
  input  logic [31:0] rdValBase,
  input  logic [31:0] rdValOff,
  input  logic [31:0] rdValSrc,
  output logic        memValid,
  input  logic        memReady,
  output logic [31:0] memAddr,
  output logic        memWrite,
  output logic [3:0]  memStrobe,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  output logic        busy,
  output logic        done,
  output logic        wbDataEn,
  output logic [3:0]  wbDataReg,
  output logic [31:0] wbDataVal,
  output logic        wbBaseEn,
  output logic [3:0]  wbBaseReg,
  output logic [31:0] wbBaseVal
);
  ctrlStrobe_t ctrlStb;
  ldMode_t     modeBits;
  logic        dataWant, baseWant;

  assign modeBits = '{i: modeI, p: modeP, u: modeU, b: modeB, w: modeW, l: modeL};

  ldst_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .memReady (memReady),
    .strobe   (ctrlStb),
    .memValid (memValid),
    .busy     (busy),
    .done     (done)
  );

  ldst_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (ctrlStb),
    .instr     (instr),
    .mode      (modeBits),
    .carryIn   (carryIn),
    .pcValue   (pcValue),
    .baseRaw   (rdValBase),
    .offRaw    (rdValOff),
    .srcRaw    (rdValSrc),
    .memRdata  (memRdata),
    .rnIdx     (rdIdxBase),
    .rmIdx     (rdIdxOff),
    .rdIdx     (rdIdxSrc),
    .memAddr   (memAddr),
    .memWrite  (memWrite),
    .memStrobe (memStrobe),
    .memWdata  (memWdata),
    .dataWant  (dataWant),
    .baseWant  (baseWant),
    .dataReg   (wbDataReg),
    .baseReg   (wbBaseReg),
    .dataVal   (wbDataVal),
    .baseVal   (wbBaseVal)
  );

  assign wbDataEn = done && dataWant;
  assign wbBaseEn = done && baseWant;
endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        memValid,
  input logic        memReady,
  input logic [31:0] memAddr,
  input logic        memWrite,
  input logic [3:0]  memStrobe,
  input logic        busy,
  input logic        done,
  input logic        wbDataEn,
  input logic [3:0]  wbDataReg,
  input logic        wbBaseEn,
  input logic [3:0]  wbBaseReg
);
  // R9: lane strobes are a single lane or all four during a request
  p_lane_r9: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> ($countones(memStrobe) == 1 || memStrobe == 4'hF));

  // R9: full-word strobes only with an aligned address
  p_word_align_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memStrobe == 4'hF) |-> memAddr[1:0] == 2'b00);

  // R12: request held with a stable address until accepted
  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr)));

  // R12: writes presented the cycle after the handshake
  p_done_after_r12: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady) |=> (done && !busy));

  // R12: done is a one-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11: both writes never target the same register
  p_same_reg_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wbDataEn && wbBaseEn) |-> (wbDataReg != wbBaseReg));

  // R11: data write only for a load
  p_store_no_data_r11: assert property (@(posedge clk) disable iff (!rstN)
    wbDataEn |-> !memWrite);

  // R12: start while idle raises the request next cycle
  p_accept_r12: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !done) |=> memValid);
endmodule

bind ldst_unit ldst_unit_chk u_chk (.*);

// File: tb/sim_ldst_unit.sv
`timescale 1ns/1ps
module sim_ldst_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic        modeI = 0, modeP = 0, modeU = 0, modeB = 0, modeW = 0, modeL = 0;
  logic        carryIn = 0;
  logic [31:0] pcValue = 32'h0000_0208;
  logic [3:0]  rdIdxBase, rdIdxOff, rdIdxSrc;
  logic [31:0] rdValBase, rdValOff, rdValSrc;
  logic        memValid, memReady = 1'b0, memWrite;
  logic [31:0] memAddr, memWdata, memRdata = '0;
  logic [3:0]  memStrobe;
  logic        busy, done, wbDataEn, wbBaseEn;
  logic [3:0]  wbDataReg, wbBaseReg;
  logic [31:0] wbDataVal, wbBaseVal;
  logic [31:0] regs [16];
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  assign rdValBase = regs[rdIdxBase];
  assign rdValOff  = regs[rdIdxOff];
  assign rdValSrc  = regs[rdIdxSrc];

  ldst_unit u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] refShift(logic [31:0] v, int amt, int kind, logic c);
    logic [31:0] r = v;
    if (amt == 0) begin
      case (kind)
        0: return v;
        1: return 32'h0;
        2: return v[31] ? 32'hFFFF_FFFF : 32'h0;
        default: return {c, v[31:1]};
      endcase
    end
    for (int k = 0; k < amt; k++) begin
      case (kind)
        0: r = {r[30:0], 1'b0};
        1: r = {1'b0, r[31:1]};
        2: r = {r[31], r[31:1]};
        default: r = {r[0], r[31:1]};
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] memWord(logic [31:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] + 8'h11, ~a[7:0], a[9:2] ^ 8'h5A};
  endfunction

  function automatic logic [31:0] rotByBytes(logic [31:0] w, int n);
    logic [31:0] r = w;
    for (int k = 0; k < n; k++) r = {r[7:0], r[31:8]};
    return r;
  endfunction

  task automatic runOne(input string tag, input logic [31:0] ins,
                        input logic i, p, u, b, w, l, input logic c, input int lat);
    logic [3:0]  rn, rd;
    logic [31:0] base, off, adj, addr, word, expData, holdAddr;
    logic        expBase, expDataEn;
    rn = ins[19:16]; rd = ins[15:12];
    base = (rn == 4'hF) ? pcValue + (l ? 32'd0 : 32'd4) : regs[rn];
    off  = i ? refShift(regs[ins[3:0]], int'(ins[11:7]), int'(ins[6:5]), c) : {20'h0, ins[11:0]};
    adj  = u ? base + off : base - off;
    addr = p ? adj : base;
    expBase   = !p || w;
    expDataEn = l && !(expBase && rd == rn);
    word = memWord({addr[31:2], 2'b00});
    expData = b ? {24'h0, 8'(word >> (8 * addr[1:0]))} : rotByBytes(word, int'(addr[1:0]));

    @(negedge clk);
    instr = ins; modeI = i; modeP = p; modeU = u; modeB = b; modeW = w; modeL = l;
    carryIn = c; start = 1'b1;
    #1;
    chk("R1 base index", {28'h0, rdIdxBase}, {28'h0, rn});
    chk("R1 data index", {28'h0, rdIdxSrc}, {28'h0, rd});
    chk("R1 offset index", {28'h0, rdIdxOff}, {28'h0, ins[3:0]});
    @(negedge clk);
    start = 1'b0;
    chk("R12 valid", {31'h0, memValid}, 32'd1);
    chk("R12 busy", {31'h0, busy}, 32'd1);
    chk(tag, memAddr, b ? addr : {addr[31:2], 2'b00});
    chk("R9 write flag", {31'h0, memWrite}, {31'h0, !l});
    chk("R9 strobe", {28'h0, memStrobe}, b ? (32'd1 << addr[1:0]) : 32'hF);
    if (!l) begin
      if (b) chk("R9 byte data", {24'h0, 8'(memWdata >> (8 * addr[1:0]))}, {24'h0, regs[rd][7:0]});
      else   chk("R9 word data", memWdata, regs[rd]);
    end
    holdAddr = memAddr;
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      chk("R12 held valid", {31'h0, memValid}, 32'd1);
      chk("R12 held addr", memAddr, holdAddr);
    end
    memReady = 1'b1;
    memRdata = memWord({addr[31:2], 2'b00});
    @(negedge clk);
    memReady = 1'b0;
    memRdata = 32'hDEAD_0000;
    chk("R12 done", {31'h0, done}, 32'd1);
    chk("R12 not busy", {31'h0, busy}, 32'd0);
    chk("R10 base enable", {31'h0, wbBaseEn}, {31'h0, expBase});
    if (expBase) begin
      chk("R10 base value", wbBaseVal, adj);
      chk("R10 base index", {28'h0, wbBaseReg}, {28'h0, rn});
    end
    chk("R11 data enable", {31'h0, wbDataEn}, {31'h0, expDataEn});
    if (expDataEn) begin
      chk(b ? "R7 byte load" : "R8 word load", wbDataVal, expData);
      chk("R11 data index", {28'h0, wbDataReg}, {28'h0, rd});
    end
    @(negedge clk);
    chk("R12 done pulse", {31'h0, done}, 32'd0);
  endtask

  function automatic logic [31:0] mkReg(logic [3:0] rn, rd, rm, logic [4:0] amt, logic [1:0] kind);
    return {12'h0, rn, rd, amt, kind, 1'b0, rm};
  endfunction

  function automatic logic [31:0] mkImm(logic [3:0] rn, rd, logic [11:0] off);
    return {12'h0, rn, rd, off};
  endfunction

  initial begin
    fork
      begin
        #1500000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
  end

  initial begin
    int amts[4] = '{0, 1, 7, 31};
    for (int k = 0; k < 16; k++) regs[k] = 32'h1357_0000 + k * 32'h0101_0013;
    regs[2] = 32'h0000_4000;
    regs[3] = 32'h9234_5679;
    regs[4] = 32'h4000_0003;
    regs[5] = 32'h0000_8000;
    regs[6] = 32'hCAFE_BA42;
    regs[7] = 32'h0000_2000;
    regs[15] = 32'h7777_7770;
    repeat (3) @(negedge clk);
    chk("R13 valid", {31'h0, memValid}, 32'd0);
    chk("R13 busy", {31'h0, busy}, 32'd0);
    chk("R13 done", {31'h0, done}, 32'd0);
    chk("R13 data enable", {31'h0, wbDataEn}, 32'd0);
    chk("R13 base enable", {31'h0, wbBaseEn}, 32'd0);
    rstN = 1'b1;

    // R4 / R5: shifted-register offsets
    for (int kind = 0; kind < 4; kind++)
      for (int a = 0; a < 4; a++)
        for (int c = 0; c < 2; c++) begin
          runOne(amts[a] == 0 ? "R5 zero shift addr" : "R4 shift addr",
                 mkReg(4'd2, 4'd6, 4'd3, 5'(amts[a]), 2'(kind)), 1, 1, 1, 0, 0, 1, c[0], a % 3);
          runOne(amts[a] == 0 ? "R5 zero shift addr" : "R4 shift addr",
                 mkReg(4'd2, 4'd6, 4'd4, 5'(amts[a]), 2'(kind)), 1, 1, 0, 0, 0, 1, c[0], 0);
        end

    // R3 / R6 / R7 / R8 / R9 / R10: immediate sweep over modes and alignments
    for (int m = 0; m < 32; m++)
      for (int low = 0; low < 4; low++)
        runOne(m[4] ? "R6 pre-index addr" : "R3 post-index addr",
               mkImm(4'd5, 4'd6, 12'(12'h100 + low + 16 * m)),
               0, m[4], m[3], m[2], m[1], m[0], 1'b0, low);

    // R2: PC base for loads and stores
    runOne("R2 pc load", mkImm(4'hF, 4'd6, 12'h010), 0, 1, 1, 0, 0, 1, 1'b0, 1);
    runOne("R2 pc store", mkImm(4'hF, 4'd6, 12'h010), 0, 1, 1, 0, 0, 0, 1'b0, 1);
    runOne("R2 pc byte store", mkImm(4'hF, 4'd6, 12'h003), 0, 1, 0, 1, 0, 0, 1'b0, 0);

    // R11: data index equal to base index
    runOne("R11 same reg pre wb", mkImm(4'd7, 4'd7, 12'h004), 0, 1, 1, 0, 1, 1, 1'b0, 0);
    runOne("R11 same reg post", mkImm(4'd7, 4'd7, 12'h006), 0, 0, 1, 0, 0, 1, 1'b0, 2);
    runOne("R11 same reg no wb", mkImm(4'd7, 4'd7, 12'h001), 0, 1, 0, 0, 0, 1, 1'b0, 1);
    runOne("R11 same reg store", mkImm(4'd7, 4'd7, 12'h008), 0, 1, 1, 0, 1, 0, 1'b0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule